// File: doc/BRIEF.md
# Flag Port Bus Strobe Sequencer

This block gives a host two 16-bit flag registers that reach the outside world over a shared external address/data bus. A host write to the output flag register is stored in an internal copy. The merged 16-bit value is then placed on the bus, and a registered active-high write strobe is pulsed so that an external transparent latch can capture it. Address and data are driven for a programmed number of clock cycles before the strobe rises and after it falls.

A host read of the input flag register runs the same bus framing with an active-low read strobe. That strobe has the timing of an ordinary I/O read. The 16 bits that external buffers drive onto the bus are captured in the last strobe cycle. Reading the output flag register returns the internal copy and makes no bus cycle.

The two registers share one 32-bit host word. The output flag register sits on byte lanes 1:0 and the input flag register on byte lanes 3:2. A single access that enables lanes of both registers is refused with an error. The host sees a one-cycle ready pulse only when the whole bus sequence has finished. Only one sequence runs at a time.

Top module: `flagport_seq`

## Requirements
- R1: After reset the output flag register holds 0x0000. The write strobe is low, the read strobe is high, the data drivers are off, `bus_addr` is zero and `host_ready` is low.
- R2: A write whose enabled lanes are all within 1:0, at word address `BASE_WORD`, updates only the enabled bytes of the output flag register. It then drives the full merged 16-bit value on `bus_data_out` with `bus_data_oe` high and `bus_addr` = {`BASE_WORD`, 2'b00}, and pulses `flag_wr_stb`.
- R3: In every bus sequence, address (and data for a write) are held steady for `SETUP_CYC` cycles before the strobe rises. The strobe stays asserted for `STROBE_CYC` cycles, and address and data stay driven for `HOLD_CYC` cycles after the strobe falls. With a 4 ns clock the defaults are 8, 15 and 5 cycles, which gives 32 ns of setup and 20 ns of hold.
- R4: A read whose enabled lanes are all within 1:0 returns {16'h0000, output flag register} on `host_rdata`. It makes no bus activity and raises `host_ready` one cycle after the request is accepted.
- R5: A read whose enabled lanes are all within 3:2 drives `bus_addr` = {`BASE_WORD`, 2'b10} with the data drivers off, and pulls `flag_rd_n` low with the R3 framing. It returns {sampled `bus_data_in`, 16'h0000}, where the sample is taken in the last strobe cycle.
- R6: An access that enables at least one lane in 1:0 and at least one in 3:2 completes after one cycle with `host_err` high and no bus activity. A read of this kind returns 0xFFFFFFFF, and a write of this kind leaves the output flag register unchanged.
- R7: A strobe stays inactive for the whole sequence if its function enable (`fn_wr_en` or `fn_rd_en`) was low when the request was accepted. The bus framing and latency do not change. A change of the enable after acceptance does not shorten or cut a strobe.
- R8: `host_ready` stays low until the sequence has ended and then pulses high for one cycle. A bus sequence completes `SETUP_CYC`+`STROBE_CYC`+`HOLD_CYC` cycles after acceptance (28 by default). `host_err` is high only together with `host_ready`.
- R9: The following complete in one cycle with no error, no bus activity and no change to the output flag register: a write to lanes 3:2 only, and any access at a word address other than `BASE_WORD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | WORD_AW | Host word address |
| host_be | input | 4 | Host byte-lane enables |
| host_rd | input | 1 | Read request, held until `host_ready` |
| host_wr | input | 1 | Write request, held until `host_ready` |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with `host_ready` |
| host_ready | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Refused access, valid with `host_ready` |
| fn_wr_en | input | 1 | Selects the write-strobe pin function |
| fn_rd_en | input | 1 | Selects the read-strobe pin function |
| bus_addr | output | WORD_AW+2 | External byte address, zero when idle |
| bus_data_out | output | 16 | External data driven on a write |
| bus_data_oe | output | 1 | Data driver enable |
| bus_data_in | input | 16 | External data seen on a read |
| flag_wr_stb | output | 1 | Active-high write strobe for the external latch |
| flag_rd_n | output | 1 | Active-low read strobe for the external buffers |

## Verification
The stimulus mixes full-width writes, single-lane writes to either byte, and readbacks placed after each write. This separates correct byte merging from plain overwrites, and shows that the bus receives the merged value rather than the raw host word. Input-register reads with different bus patterns and lane subsets show that the capture comes from the bus on the right half of the word. Lane patterns that span both registers, writes to the read-only lanes and a foreign word address are each followed by a readback, so silent corruption of the stored copy would be visible. Sequences with the function enables low, and with an enable dropped mid-strobe, separate gated strobes from shortened strobes or changed framing.

// File: rtl/flagport_pkg.sv
// Shared types and timing helpers for the flag port sequencer.
// Assumes byte lanes of 8 bits and two 16-bit registers in one 32-bit host word.
package flagport_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_SETUP  = 3'd1,
        SEQ_STROBE = 3'd2,
        SEQ_HOLD   = 3'd3,
        SEQ_DONE   = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        OPK_LOCAL  = 2'd0,
        OPK_BUS_WR = 2'd1,
        OPK_BUS_RD = 2'd2
    } op_kind_t;

    localparam int unsigned LANE_W     = 8;
    localparam int unsigned FLAG_W     = 16;
    localparam int unsigned FLAG_LANES = FLAG_W / LANE_W;
    localparam int unsigned HOST_LANES = 2 * FLAG_LANES;
    localparam int unsigned HOST_W     = HOST_LANES * LANE_W;

    localparam int unsigned DEF_CLK_PS    = 4000;
    localparam int unsigned DEF_SETUP_PS  = 30000;
    localparam int unsigned DEF_HOLD_PS   = 20000;
    localparam int unsigned DEF_STROBE_PS = 60000;

    // Rounds a time window up to whole clock cycles, never below one.
    function automatic int unsigned cyc_for(input int unsigned ps, input int unsigned clk_ps);
        int unsigned c;
        c = (ps + clk_ps - 1) / clk_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/flagport_decode.sv
// Host request decoder: classifies an access by word address and byte lanes,
// builds the merged output-flag value and any read data served locally.
// Assumes the output flag register on low lanes and the input flag register on high lanes.
module flagport_decode
    import flagport_pkg::*;
#(
    parameter int unsigned WORD_AW = 6,
    parameter logic [WORD_AW-1:0] BASE_WORD = 6'h09
) (
    input  logic [WORD_AW-1:0]    addr,
    input  logic [HOST_LANES-1:0] be,
    input  logic                  rd,
    input  logic [FLAG_W-1:0]     wdata_lo,
    input  logic [FLAG_W-1:0]     shadow,
    output op_kind_t              kind,
    output logic                  err,
    output logic [HOST_W-1:0]     local_rdata,
    output logic                  shadow_we,
    output logic [FLAG_W-1:0]     shadow_nxt
);

    logic hit;
    logic lo_any;
    logic hi_any;

    assign hit    = (addr == BASE_WORD);
    assign lo_any = |be[FLAG_LANES-1:0];
    assign hi_any = |be[HOST_LANES-1:FLAG_LANES];

    // Per-lane merge of host data into the stored output flag value.
    for (genvar g = 0; g < FLAG_LANES; g++) begin : g_lane
        assign shadow_nxt[g*LANE_W +: LANE_W] = be[g] ? wdata_lo[g*LANE_W +: LANE_W]
                                                      : shadow[g*LANE_W +: LANE_W];
    end

    // Classify the access and pick the local response.
    always_comb begin
        kind        = OPK_LOCAL;
        err         = 1'b0;
        local_rdata = '0;
        shadow_we   = 1'b0;
        if (hit && lo_any && hi_any) begin
            err = 1'b1;
            if (rd) local_rdata = '1;
        end else if (hit && lo_any) begin
            if (rd) begin
                local_rdata = {{(HOST_W-FLAG_W){1'b0}}, shadow};
            end else begin
                kind      = OPK_BUS_WR;
                shadow_we = 1'b1;
            end
        end else if (hit && hi_any) begin
            if (rd) kind = OPK_BUS_RD;
        end
    end

endmodule

// File: rtl/flagport_timer.sv
// Loadable down counter that times the setup, strobe and hold phases.
// Assumes a load value of N-1 for an N-cycle phase; expired is high at zero.
module flagport_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, else count down to zero and stay.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/flagport_fsm.sv
// Bus sequencer: frames one external access as setup, strobe and hold phases,
// drives all pins from flops and captures read data at the end of the strobe.
// Assumes start is only raised while idle; phase lengths are at least one cycle.
module flagport_fsm
    import flagport_pkg::*;
#(
    parameter int unsigned BUS_AW     = 8,
    parameter int unsigned SETUP_CYC  = 8,
    parameter int unsigned STROBE_CYC = 15,
    parameter int unsigned HOLD_CYC   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_kind_t          kind,
    input  logic [BUS_AW-1:0] start_addr,
    input  logic [FLAG_W-1:0] start_data,
    input  logic              fn_wr_en,
    input  logic              fn_rd_en,
    input  logic [FLAG_W-1:0] bus_data_in,
    output logic              idle,
    output logic              done,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [FLAG_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic              wr_stb,
    output logic              rd_stb_n,
    output logic [FLAG_W-1:0] cap_data
);

    localparam int unsigned MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int unsigned MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

    seq_state_t        st_q, st_n;
    op_kind_t          kind_q, kind_eff;
    logic              fnw_q, fnr_q, fnw_eff, fnr_eff;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic              expired;
    logic              active_n;
    logic [BUS_AW-1:0] addr_q;
    logic [FLAG_W-1:0] data_q;
    logic              oe_q, wr_q, rdn_q, done_q;
    logic [FLAG_W-1:0] cap_q;

    flagport_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    // Phase transitions and timer loads.
    always_comb begin
        st_n   = st_q;
        ld     = 1'b0;
        ld_val = '0;
        case (st_q)
            SEQ_IDLE: begin
                if (start) begin
                    if (kind == OPK_LOCAL) begin
                        st_n = SEQ_DONE;
                    end else begin
                        st_n   = SEQ_SETUP;
                        ld     = 1'b1;
                        ld_val = SETUP_LD;
                    end
                end
            end
            SEQ_SETUP: begin
                if (expired) begin
                    st_n   = SEQ_STROBE;
                    ld     = 1'b1;
                    ld_val = STROBE_LD;
                end
            end
            SEQ_STROBE: begin
                if (expired) begin
                    st_n   = SEQ_HOLD;
                    ld     = 1'b1;
                    ld_val = HOLD_LD;
                end
            end
            SEQ_HOLD: begin
                if (expired) st_n = SEQ_DONE;
            end
            SEQ_DONE: st_n = SEQ_IDLE;
            default:  st_n = SEQ_IDLE;
        endcase
    end

    // Request attributes seen by the output logic: live at start, latched after.
    always_comb begin
        kind_eff = (st_q == SEQ_IDLE) ? kind     : kind_q;
        fnw_eff  = (st_q == SEQ_IDLE) ? fn_wr_en : fnw_q;
        fnr_eff  = (st_q == SEQ_IDLE) ? fn_rd_en : fnr_q;
        active_n = (st_n == SEQ_SETUP) || (st_n == SEQ_STROBE) || (st_n == SEQ_HOLD);
    end

    // State register and request attribute latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            kind_q <= OPK_LOCAL;
            fnw_q  <= 1'b0;
            fnr_q  <= 1'b0;
        end else begin
            st_q <= st_n;
            if (st_q == SEQ_IDLE && start) begin
                kind_q <= kind;
                fnw_q  <= fn_wr_en;
                fnr_q  <= fn_rd_en;
            end
        end
    end

    // Address and data held steady from acceptance until the sequence ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (st_q == SEQ_IDLE && start && kind != OPK_LOCAL) begin
            addr_q <= start_addr;
            data_q <= (kind == OPK_BUS_WR) ? start_data : '0;
        end else if (st_n == SEQ_DONE) begin
            addr_q <= '0;
            data_q <= '0;
        end
    end

    // Registered pin controls, so strobes never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            wr_q   <= 1'b0;
            rdn_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            oe_q   <= active_n && (kind_eff == OPK_BUS_WR);
            wr_q   <= (st_n == SEQ_STROBE) && (kind_eff == OPK_BUS_WR) && fnw_eff;
            rdn_q  <= !((st_n == SEQ_STROBE) && (kind_eff == OPK_BUS_RD) && fnr_eff);
            done_q <= (st_n == SEQ_DONE);
        end
    end

    // Capture external read data in the last strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (st_q == SEQ_STROBE && expired && kind_q == OPK_BUS_RD)
            cap_q <= bus_data_in;
    end

    assign idle         = (st_q == SEQ_IDLE);
    assign done         = done_q;
    assign bus_addr     = addr_q;
    assign bus_data_out = data_q;
    assign bus_data_oe  = oe_q;
    assign wr_stb       = wr_q;
    assign rd_stb_n     = rdn_q;
    assign cap_data     = cap_q;

endmodule

// File: rtl/flagport_seq.sv
// Top of the flag port sequencer: holds the output flag copy, accepts one host
// request at a time and hands bus work to the sequencer.
// Assumes the host holds rd or wr steady until it sees host_ready.
module flagport_seq
    import flagport_pkg::*;
#(
    parameter int unsigned WORD_AW       = 6,
    parameter logic [WORD_AW-1:0] BASE_WORD = 6'h09,
    parameter int unsigned CLK_PERIOD_PS = DEF_CLK_PS,
    parameter int unsigned SETUP_PS      = DEF_SETUP_PS,
    parameter int unsigned HOLD_PS       = DEF_HOLD_PS,
    parameter int unsigned STROBE_PS     = DEF_STROBE_PS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_AW-1:0] host_addr,
    input  logic [3:0]         host_be,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               host_ready,
    output logic               host_err,
    input  logic               fn_wr_en,
    input  logic               fn_rd_en,
    output logic [WORD_AW+1:0] bus_addr,
    output logic [15:0]        bus_data_out,
    output logic               bus_data_oe,
    input  logic [15:0]        bus_data_in,
    output logic               flag_wr_stb,
    output logic               flag_rd_n
);

    localparam int unsigned BUS_AW     = WORD_AW + 2;
    localparam int unsigned SETUP_CYC  = cyc_for(SETUP_PS, CLK_PERIOD_PS);
    localparam int unsigned HOLD_CYC   = cyc_for(HOLD_PS, CLK_PERIOD_PS);
    localparam int unsigned STROBE_CYC = cyc_for(STROBE_PS, CLK_PERIOD_PS);

    op_kind_t          dec_kind, kind_q;
    logic              dec_err, err_q;
    logic [HOST_W-1:0] dec_rdata, local_q;
    logic              dec_we;
    logic [FLAG_W-1:0] merged;
    logic [FLAG_W-1:0] shadow_q;
    logic              seq_idle, seq_done, accept;
    logic [FLAG_W-1:0] cap_data;
    logic [BUS_AW-1:0] start_addr;
    logic [15:0]       unused_wdata_hi;

    assign unused_wdata_hi = host_wdata[31:16];
    assign accept          = (host_rd || host_wr) && seq_idle;
    assign start_addr      = {host_addr, (dec_kind == OPK_BUS_RD) ? 2'b10 : 2'b00};

    flagport_decode #(
        .WORD_AW   (WORD_AW),
        .BASE_WORD (BASE_WORD)
    ) u_decode (
        .addr        (host_addr),
        .be          (host_be),
        .rd          (host_rd),
        .wdata_lo    (host_wdata[15:0]),
        .shadow      (shadow_q),
        .kind        (dec_kind),
        .err         (dec_err),
        .local_rdata (dec_rdata),
        .shadow_we   (dec_we),
        .shadow_nxt  (merged)
    );

    flagport_fsm #(
        .BUS_AW     (BUS_AW),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept),
        .kind         (dec_kind),
        .start_addr   (start_addr),
        .start_data   (merged),
        .fn_wr_en     (fn_wr_en),
        .fn_rd_en     (fn_rd_en),
        .bus_data_in  (bus_data_in),
        .idle         (seq_idle),
        .done         (seq_done),
        .bus_addr     (bus_addr),
        .bus_data_out (bus_data_out),
        .bus_data_oe  (bus_data_oe),
        .wr_stb       (flag_wr_stb),
        .rd_stb_n     (flag_rd_n),
        .cap_data     (cap_data)
    );

    // Output flag copy: updated at acceptance of a legal write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 shadow_q <= '0;
        else if (accept && dec_we)  shadow_q <= merged;
    end

    // Per-request response state kept until the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= OPK_LOCAL;
            err_q   <= 1'b0;
            local_q <= '0;
        end else if (accept) begin
            kind_q  <= dec_kind;
            err_q   <= dec_err;
            local_q <= dec_rdata;
        end
    end

    assign host_ready = seq_done;
    assign host_err   = seq_done && err_q;
    assign host_rdata = (kind_q == OPK_BUS_RD) ? {cap_data, {(HOST_W-FLAG_W){1'b0}}} : local_q;

endmodule

// File: rtl/flagport_seq_chk.sv
// Protocol checker for flagport_seq, attached by bind. Uses the default timing.
module flagport_seq_chk
    import flagport_pkg::*;
#(
    parameter int unsigned BUS_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic              host_err,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [15:0]       bus_data_out,
    input logic              bus_data_oe,
    input logic              flag_wr_stb,
    input logic              flag_rd_n
);

    localparam int unsigned SETUP_CYC = cyc_for(DEF_SETUP_PS, DEF_CLK_PS);
    localparam int unsigned HOLD_CYC  = cyc_for(DEF_HOLD_PS, DEF_CLK_PS);

    logic       active, stb_any, saw_q;
    logic [7:0] pre_q, post_q;

    assign active  = (bus_addr != '0);
    assign stb_any = flag_wr_stb || !flag_rd_n;

    // Counts quiet cycles before and after the strobe within one bus sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            pre_q  <= '0;
            post_q <= '0;
            saw_q  <= 1'b0;
        end else begin
            if (stb_any) saw_q <= 1'b1;
            if (!stb_any && !saw_q && pre_q != 8'hFF)  pre_q  <= pre_q + 1'b1;
            if (!stb_any && saw_q && post_q != 8'hFF)  post_q <= post_q + 1'b1;
        end
    end

    assert_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_any) |-> (pre_q >= SETUP_CYC));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active) && saw_q) |-> (post_q >= HOLD_CYC));

    assert_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> ($stable(bus_addr) && $stable(bus_data_out)));

    assert_wr_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr_stb |-> bus_data_oe);

    assert_rd_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_rd_n |-> (!bus_data_oe && !flag_wr_stb));

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    assert_err_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_ready);

endmodule

bind flagport_seq flagport_seq_chk #(.BUS_AW(8)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ready   (host_ready),
    .host_err     (host_err),
    .bus_addr     (bus_addr),
    .bus_data_out (bus_data_out),
    .bus_data_oe  (bus_data_oe),
    .flag_wr_stb  (flag_wr_stb),
    .flag_rd_n    (flag_rd_n)
);

// File: tb/flagport_seq_tb.sv
`timescale 1ns/1ps
module flagport_seq_tb;

    localparam logic [5:0] BASE = 6'h09;
    localparam int S = 8, W = 15, H = 5;
    localparam int BUS_LAT = S + W + H + 1;

    typedef struct packed {
        logic        rd;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [15:0] bus_in;
        logic        fnw;
        logic        fnr;
        logic [31:0] exp_rdata;
        logic        exp_err;
        logic [1:0]  exp_kind;   // 0 none, 1 bus write, 2 bus read
        logic [15:0] exp_bus;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'b0011, 32'h0000A5C3, 16'h0000, 1'b1, 1'b1, 32'h0,        1'b0, 2'd1, 16'hA5C3},
        '{1'b1, 4'b0011, 32'h0,        16'h0000, 1'b1, 1'b1, 32'h0000A5C3, 1'b0, 2'd0, 16'h0},
        '{1'b0, 4'b0001, 32'h0000FF5A, 16'h0000, 1'b1, 1'b1, 32'h0,        1'b0, 2'd1, 16'hA55A},
        '{1'b1, 4'b0010, 32'h0,        16'h0000, 1'b1, 1'b1, 32'h0000A55A, 1'b0, 2'd0, 16'h0},
        '{1'b1, 4'b1100, 32'h0,        16'h3C96, 1'b1, 1'b1, 32'h3C960000, 1'b0, 2'd2, 16'h0},
        '{1'b1, 4'b1111, 32'h0,        16'h5555, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b1, 2'd0, 16'h0},
        '{1'b0, 4'b0110, 32'hFFFFFFFF, 16'h0000, 1'b1, 1'b1, 32'h0,        1'b1, 2'd0, 16'h0},
        '{1'b0, 4'b1100, 32'h12340000, 16'h0000, 1'b1, 1'b1, 32'h0,        1'b0, 2'd0, 16'h0},
        '{1'b1, 4'b0011, 32'h0,        16'h0000, 1'b1, 1'b1, 32'h0000A55A, 1'b0, 2'd0, 16'h0},
        '{1'b0, 4'b0011, 32'h00000F0F, 16'h0000, 1'b0, 1'b1, 32'h0,        1'b0, 2'd1, 16'h0F0F},
        '{1'b1, 4'b1100, 32'h0,        16'h7E81, 1'b1, 1'b0, 32'h7E810000, 1'b0, 2'd2, 16'h0},
        '{1'b1, 4'b0011, 32'h0,        16'h0000, 1'b1, 1'b1, 32'h00000F0F, 1'b0, 2'd0, 16'h0},
        '{1'b0, 4'b0010, 32'h0000BB00, 16'h0000, 1'b1, 1'b1, 32'h0,        1'b0, 2'd1, 16'hBB0F},
        '{1'b1, 4'b0011, 32'h0,        16'h0000, 1'b1, 1'b1, 32'h0000BB0F, 1'b0, 2'd0, 16'h0},
        '{1'b1, 4'b0100, 32'h0,        16'h1111, 1'b1, 1'b1, 32'h11110000, 1'b0, 2'd2, 16'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [3:0]  host_be = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready, host_err;
    logic        fn_wr_en = 1'b0, fn_rd_en = 1'b0;
    logic [7:0]  bus_addr;
    logic [15:0] bus_data_out;
    logic        bus_data_oe;
    logic [15:0] bus_data_in = '0;
    logic        flag_wr_stb, flag_rd_n;

    int n_checks = 0, n_errs = 0, cycles = 0;
    int m_lat, m_act, m_pre, m_wid, m_post, m_oe, m_wrs, m_rds;
    logic [7:0]  m_addr;
    logic [15:0] m_data;
    logic [31:0] m_rdata;
    logic        m_err;

    flagport_seq u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_be(host_be),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .host_err(host_err),
        .fn_wr_en(fn_wr_en), .fn_rd_en(fn_rd_en), .bus_addr(bus_addr),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .bus_data_in(bus_data_in), .flag_wr_stb(flag_wr_stb), .flag_rd_n(flag_rd_n)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++; n_errs++;
            $display("FAIL R8 watchdog: got %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One host access; records bus framing seen at each negative edge.
    task automatic do_access(input logic [5:0] addr, input logic rd, input logic [3:0] be,
                             input logic [31:0] wd, input logic [15:0] bin,
                             input logic fnw, input logic fnr, input int drop_at);
        bit seen = 0;
        m_lat = 0; m_act = 0; m_pre = 0; m_wid = 0; m_post = 0; m_oe = 0; m_wrs = 0; m_rds = 0;
        m_addr = '0; m_data = '0;
        @(negedge clk);
        host_addr = addr; host_be = be; host_wdata = wd; bus_data_in = bin;
        fn_wr_en = fnw; fn_rd_en = fnr;
        host_rd = rd; host_wr = !rd;
        while (1) begin
            @(negedge clk);
            m_lat++;
            if (m_lat == drop_at) begin fn_wr_en = 1'b0; fn_rd_en = 1'b0; end
            if (flag_wr_stb) m_wrs++;
            if (!flag_rd_n)  m_rds++;
            if (bus_data_oe) begin m_oe++; m_data = bus_data_out; end
            if (bus_addr != 8'h00) begin
                m_act++; m_addr = bus_addr;
                if (flag_wr_stb || !flag_rd_n) begin m_wid++; seen = 1; end
                else if (!seen) m_pre++;
                else m_post++;
            end
            if (host_ready) begin
                m_err = host_err; m_rdata = host_rdata;
                break;
            end
            if (m_lat > 200) begin
                chk("R8 ready timeout", 32'(m_lat), 32'(BUS_LAT));
                break;
            end
        end
        host_rd = 1'b0; host_wr = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: state right after reset
        chk("R1 wr strobe idle", {31'h0, flag_wr_stb}, 32'h0);
        chk("R1 rd strobe idle", {31'h0, flag_rd_n}, 32'h1);
        chk("R1 data driver off", {31'h0, bus_data_oe}, 32'h0);
        chk("R1 ready low", {31'h0, host_ready}, 32'h0);
        chk("R1 bus addr zero", {24'h0, bus_addr}, 32'h0);
        rst_n = 1'b1;
        do_access(BASE, 1'b1, 4'b0011, 32'h0, 16'h0, 1'b1, 1'b1, 0);
        chk("R1 flag register reset value", m_rdata, 32'h0);

        // Table of vectors walked by one loop
        for (int i = 0; i < NV; i++) begin
            do_access(BASE, VECS[i].rd, VECS[i].be, VECS[i].wdata, VECS[i].bus_in,
                      VECS[i].fnw, VECS[i].fnr, 0);
            chk(VECS[i].exp_err ? "R6 error flag" : "R8 no error", {31'h0, m_err}, {31'h0, VECS[i].exp_err});
            if (VECS[i].rd)
                chk(VECS[i].exp_err ? "R6 spanning read data" :
                    (VECS[i].exp_kind == 2'd2 ? "R5 captured read data" : "R4 readback data"),
                    m_rdata, VECS[i].exp_rdata);
            case (VECS[i].exp_kind)
                2'd0: begin
                    chk("R4 R6 R9 local latency", 32'(m_lat), 32'd1);
                    chk("R4 R6 R9 no bus activity", 32'(m_act + m_oe + m_wrs + m_rds), 32'd0);
                end
                2'd1: begin
                    chk("R8 write latency", 32'(m_lat), 32'(BUS_LAT));
                    chk("R2 bus write data", {16'h0, m_data}, {16'h0, VECS[i].exp_bus});
                    chk("R2 bus write address", {24'h0, m_addr}, {24'h0, BASE, 2'b00});
                    chk("R3 data driven window", 32'(m_oe), 32'(S + W + H));
                    chk("R7 write strobe cycles", 32'(m_wrs), VECS[i].fnw ? 32'(W) : 32'd0);
                    if (VECS[i].fnw) begin
                        chk("R3 write setup", 32'(m_pre), 32'(S));
                        chk("R3 write hold", 32'(m_post), 32'(H));
                    end
                end
                default: begin
                    chk("R8 read latency", 32'(m_lat), 32'(BUS_LAT));
                    chk("R5 bus read address", {24'h0, m_addr}, {24'h0, BASE, 2'b10});
                    chk("R5 no data drive on read", 32'(m_oe + m_wrs), 32'd0);
                    chk("R7 read strobe cycles", 32'(m_rds), VECS[i].fnr ? 32'(W) : 32'd0);
                    chk("R3 read framing", 32'(m_act), 32'(S + W + H));
                    if (VECS[i].fnr) begin
                        chk("R3 read setup", 32'(m_pre), 32'(S));
                        chk("R3 read hold", 32'(m_post), 32'(H));
                    end
                end
            endcase
        end

        // R9: foreign word address is ignored
        do_access(BASE + 6'h1, 1'b0, 4'b0011, 32'h00007777, 16'h0, 1'b1, 1'b1, 0);
        chk("R9 foreign address latency", 32'(m_lat), 32'd1);
        chk("R9 foreign address no bus", 32'(m_act + m_oe + m_wrs), 32'd0);
        chk("R9 foreign address no error", {31'h0, m_err}, 32'h0);
        do_access(BASE, 1'b1, 4'b0011, 32'h0, 16'h0, 1'b1, 1'b1, 0);
        chk("R9 register unchanged", m_rdata, 32'h0000BB0F);

        // R7: dropping the enable mid-strobe must not cut the strobe
        do_access(BASE, 1'b0, 4'b0011, 32'h00001357, 16'h0, 1'b1, 1'b1, S + 3);
        chk("R7 strobe width after enable drop", 32'(m_wrs), 32'(W));
        chk("R2 data after enable drop", {16'h0, m_data}, 32'h00001357);

        // R1: reset mid-run clears the stored flag value
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 strobes idle in reset", {30'h0, flag_wr_stb, flag_rd_n}, 32'h1);
        rst_n = 1'b1;
        do_access(BASE, 1'b1, 4'b0011, 32'h0, 16'h0, 1'b1, 1'b1, 0);
        chk("R1 flag register cleared", m_rdata, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule